// File: doc/BRIEF.md
# Register Rename Stage with Map Table and Free Pool

This block renames one instruction per cycle for a small out-of-order core. Each architectural register name points to one entry of a larger physical register file through a map table. Physical registers that are not mapped wait in a circular free pool. An incoming instruction carries two source names and one destination name. The block reads the current physical tags of both sources. It takes a fresh physical tag from the head of the free pool for the destination, and it records that tag in the map table as the new home of the destination name.

The block also reports the physical tag that the destination name held before this instruction. A later commit stage keeps that tag and returns it through the release port once no reader needs it any more. Released tags join the pool at its tail. When the pool is empty, the stall output is raised and the request is refused with no state change. Source tags are always read from the map as it stood before the current instruction, so an instruction that names the same register as source and destination reads the older location.

Top module: `reg_rename_stage`

## Requirements
- R1: Names R1..R4 are encoded 0..3 on 2 bits, and tags P1..P8 are encoded 0..7 on 3 bits. After reset, Rk maps to Pk, P5..P8 are free, and `ren_stall` is low.
- R2: `src_a_tag` and `src_b_tag` show the tags currently mapped to `ren_src_a` and `ren_src_b`, whether or not `ren_valid` is set.
- R3: An accepted request gets `dst_new_tag` from the head of the free pool. From reset, the destinations come out in the order P5, P6, P7, P8.
- R4: When a source names the instruction's own destination, its tag is the mapping from before this instruction.
- R5: `dst_old_tag` shows the tag that `ren_dst` was mapped to before the request.
- R6: After an accepted request, later lookups of the destination name return the newly given tag.
- R7: `ren_stall` is high exactly when the free pool is empty. A request made while stalled is not accepted, and it changes neither the map nor the pool.
- R8: A release (`rel_valid` with `rel_tag`) appends the tag at the pool's tail. Later allocations return the released tags in the order they were released.
- R9: A release and an accepted allocation in the same cycle both take effect, and they leave the pool count unchanged.
- R10: A release that arrives while the pool already holds four tags, and no allocation happens in that cycle, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_src_a | input | 2 | First source name |
| ren_src_b | input | 2 | Second source name |
| ren_dst | input | 2 | Destination name |
| rel_valid | input | 1 | Release request present |
| rel_tag | input | 3 | Physical tag to return to the pool |
| ren_stall | output | 1 | Free pool empty; the request is refused |
| src_a_tag | output | 3 | Physical tag of the first source |
| src_b_tag | output | 3 | Physical tag of the second source |
| dst_new_tag | output | 3 | Tag given to the destination |
| dst_old_tag | output | 3 | Tag the destination held before |

## Verification
The first test is a four-instruction chain that reuses names as both sources and destinations. It separates a correct lookup before the update from a lookup that sees the new mapping, and it shows the strict ascending allocation order. Next, the pool is drained and a request is made against the empty pool. Plain lookups then show that the map did not change. Tags are then released one at a time and alongside a rename, which shows FIFO order at the tail and the balanced count. Finally, the pool is overfilled with one extra release, and the bench counts how many allocations succeed before the next stall. This shows whether the extra tag was dropped.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int NUM_ARCH = 4;
    localparam int NUM_PHYS = 8;
    localparam int ARCH_W   = $clog2(NUM_ARCH);
    localparam int PHYS_W   = $clog2(NUM_PHYS);
    localparam int FL_DEPTH = NUM_PHYS - NUM_ARCH;
    localparam int FL_PTR_W = $clog2(FL_DEPTH);
    localparam int FL_CNT_W = $clog2(FL_DEPTH + 1);

    typedef logic [ARCH_W-1:0]   arch_t;
    typedef logic [PHYS_W-1:0]   phys_t;
    typedef phys_t [NUM_ARCH-1:0] map_vec_t;
    typedef logic [FL_PTR_W-1:0] fl_ptr_t;
    typedef logic [FL_CNT_W-1:0] fl_cnt_t;
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table
    import rename_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     upd_en,
    input  arch_t    upd_arch,
    input  phys_t    upd_phys,
    input  arch_t    rd_a,
    input  arch_t    rd_b,
    input  arch_t    rd_c,
    output phys_t    rd_a_phys,
    output phys_t    rd_b_phys,
    output phys_t    rd_c_phys,
    output map_vec_t map_o
);
    typedef struct packed {
        map_vec_t map;
    } map_state_t;

    map_state_t st_d, st_q;

    function automatic map_state_t reset_state();
        map_state_t s;
        for (int i = 0; i < NUM_ARCH; i++) begin
            s.map[i] = phys_t'(i);
        end
        return s;
    endfunction

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.map[upd_arch] = upd_phys;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    // reads use registered state: pre-update view within an instruction
    assign rd_a_phys = st_q.map[rd_a];
    assign rd_b_phys = st_q.map[rd_b];
    assign rd_c_phys = st_q.map[rd_c];
    assign map_o     = st_q.map;
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
    import rename_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pop_req,
    input  logic    push_req,
    input  phys_t   push_tag,
    output phys_t   head_tag,
    output logic    empty,
    output fl_cnt_t count_o
);
    typedef struct packed {
        phys_t [FL_DEPTH-1:0] slot;
        fl_ptr_t              head;
        fl_ptr_t              tail;
        fl_cnt_t              count;
    } fl_state_t;

    fl_state_t st_d, st_q;
    logic      pop_ok, push_ok;

    function automatic fl_ptr_t ptr_inc(input fl_ptr_t p);
        if (p == fl_ptr_t'(FL_DEPTH - 1)) begin
            return '0;
        end
        return p + fl_ptr_t'(1);
    endfunction

    function automatic fl_state_t reset_state();
        fl_state_t s;
        for (int i = 0; i < FL_DEPTH; i++) begin
            s.slot[i] = phys_t'(NUM_ARCH + i);
        end
        s.head  = '0;
        s.tail  = '0;
        s.count = fl_cnt_t'(FL_DEPTH);
        return s;
    endfunction

    always_comb begin
        pop_ok  = pop_req && (st_q.count != '0);
        push_ok = push_req && ((st_q.count != fl_cnt_t'(FL_DEPTH)) || pop_ok);
        st_d    = st_q;
        if (pop_ok) begin
            st_d.head = ptr_inc(st_q.head);
        end
        if (push_ok) begin
            st_d.slot[st_q.tail] = push_tag;
            st_d.tail            = ptr_inc(st_q.tail);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.count = st_q.count + fl_cnt_t'(1);
            2'b01:   st_d.count = st_q.count - fl_cnt_t'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign head_tag = st_q.slot[st_q.head];
    assign empty    = (st_q.count == '0);
    assign count_o  = st_q.count;
endmodule

// File: rtl/reg_rename_stage.sv
module reg_rename_stage
    import rename_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic [ARCH_W-1:0] ren_src_a,
    input  logic [ARCH_W-1:0] ren_src_b,
    input  logic [ARCH_W-1:0] ren_dst,
    input  logic              rel_valid,
    input  logic [PHYS_W-1:0] rel_tag,
    output logic              ren_stall,
    output logic [PHYS_W-1:0] src_a_tag,
    output logic [PHYS_W-1:0] src_b_tag,
    output logic [PHYS_W-1:0] dst_new_tag,
    output logic [PHYS_W-1:0] dst_old_tag
);
    logic     pool_empty;
    logic     alloc;
    fl_cnt_t  fl_count;
    map_vec_t map_vec;

    assign alloc     = ren_valid && !pool_empty;
    assign ren_stall = pool_empty;

    rename_free_list u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_req  (alloc),
        .push_req (rel_valid),
        .push_tag (rel_tag),
        .head_tag (dst_new_tag),
        .empty    (pool_empty),
        .count_o  (fl_count)
    );

    rename_map_table u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (alloc),
        .upd_arch  (ren_dst),
        .upd_phys  (dst_new_tag),
        .rd_a      (ren_src_a),
        .rd_b      (ren_src_b),
        .rd_c      (ren_dst),
        .rd_a_phys (src_a_tag),
        .rd_b_phys (src_b_tag),
        .rd_c_phys (dst_old_tag),
        .map_o     (map_vec)
    );
endmodule

// File: rtl/rename_checker.sv
module rename_checker
    import rename_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     ren_valid,
    input arch_t    ren_dst,
    input logic     ren_stall,
    input logic     rel_valid,
    input phys_t    dst_new_tag,
    input fl_cnt_t  fl_count,
    input map_vec_t map_vec
);
    // R6: accepted rename records the new tag for the destination
    p_map_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_stall) |=> (map_vec[$past(ren_dst)] == $past(dst_new_tag)));

    // R7: refused request leaves map and pool untouched
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_stall && !rel_valid) |=> ($stable(map_vec) && $stable(fl_count)));

    // R9: release plus accepted allocation keeps the count
    p_count_balance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_stall && rel_valid) |=> (fl_count == $past(fl_count)));

    // R10: pool never holds more than its depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= fl_cnt_t'(FL_DEPTH));

    // R3: a lone allocation drops the count by one
    p_alloc_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_stall && !rel_valid) |=> (fl_count == $past(fl_count) - fl_cnt_t'(1)));
endmodule

bind reg_rename_stage rename_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ren_valid   (ren_valid),
    .ren_dst     (ren_dst),
    .ren_stall   (ren_stall),
    .rel_valid   (rel_valid),
    .dst_new_tag (dst_new_tag),
    .fl_count    (fl_count),
    .map_vec     (map_vec)
);

// File: tb/sim_reg_rename_stage.sv
module sim_reg_rename_stage;
    import rename_pkg::*;

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    logic  ren_valid = 1'b0;
    arch_t ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic  rel_valid = 1'b0;
    phys_t rel_tag = '0;
    logic  ren_stall;
    phys_t src_a_tag, src_b_tag, dst_new_tag, dst_old_tag;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    a, b, n, o;
        string src_req;
        string new_req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    reg_rename_stage u0 (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .rel_valid(rel_valid), .rel_tag(rel_tag), .ren_stall(ren_stall),
        .src_a_tag(src_a_tag), .src_b_tag(src_b_tag),
        .dst_new_tag(dst_new_tag), .dst_old_tag(dst_old_tag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit rv, input int s0, input int s1, input int d,
                         input bit lv, input int lt);
        @(negedge clk);
        ren_valid = rv;
        ren_src_a = arch_t'(s0);
        ren_src_b = arch_t'(s1);
        ren_dst   = arch_t'(d);
        rel_valid = lv;
        rel_tag   = phys_t'(lt);
    endtask

    task automatic rename(input int s0, input int s1, input int d,
                          input int ea, input int eb, input int en, input int eo,
                          input string sreq, input string nreq,
                          input bit lv = 1'b0, input int lt = 0);
        exp_t e;
        e.a = ea; e.b = eb; e.n = en; e.o = eo;
        e.src_req = sreq; e.new_req = nreq;
        sb.push_back(e);
        drive(1'b1, s0, s1, d, lv, lt);
    endtask

    task automatic release_tag(input int lt);
        drive(1'b0, 0, 0, 0, 1'b1, lt);
    endtask

    task automatic peek(input int s0, input int s1, input int ea, input int eb,
                        input string req);
        drive(1'b0, s0, s1, 0, 1'b0, 0);
        #2;
        chk(int'(src_a_tag) == ea, req, "lookup a", int'(src_a_tag), ea);
        chk(int'(src_b_tag) == eb, req, "lookup b", int'(src_b_tag), eb);
    endtask

    task automatic stalled_attempt(input int s0, input int s1, input int d,
                                   input string req);
        drive(1'b1, s0, s1, d, 1'b0, 0);
        #2;
        chk(ren_stall == 1'b1, req, "stall on empty pool", int'(ren_stall), 1);
    endtask

    // monitor: pops expected results whenever a request is accepted
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && ren_valid && !ren_stall) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7", "unexpected accept", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(src_a_tag) == e.a, e.src_req, "src a tag", int'(src_a_tag), e.a);
                    chk(int'(src_b_tag) == e.b, e.src_req, "src b tag", int'(src_b_tag), e.b);
                    chk(int'(dst_new_tag) == e.n, e.new_req, "new tag", int'(dst_new_tag), e.n);
                    chk(int'(dst_old_tag) == e.o, "R5", "old tag", int'(dst_old_tag), e.o);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: identity mapping and free pool after reset
        peek(0, 1, 0, 1, "R1");
        peek(2, 3, 2, 3, "R1");
        chk(ren_stall == 1'b0, "R1", "stall after reset", int'(ren_stall), 0);
        // R2 R3: four-instruction chain, ascending allocation
        rename(1, 3, 0, 1, 3, 4, 0, "R2", "R3");
        rename(0, 1, 3, 4, 1, 5, 3, "R2", "R3");
        rename(0, 2, 2, 4, 2, 6, 2, "R4", "R3");  // R4: src R3 reads old P3
        rename(2, 1, 0, 6, 1, 7, 4, "R2", "R3");
        // R7: empty pool refuses, map unchanged (R6 visible in lookups)
        stalled_attempt(1, 1, 1, "R7");
        peek(0, 1, 7, 1, "R6");
        peek(2, 3, 6, 5, "R7");
        // R8 R9: release, then release alongside a rename
        release_tag(0);
        rename(0, 0, 1, 7, 7, 0, 1, "R2", "R9", 1'b1, 3);
        rename(2, 3, 2, 6, 5, 3, 6, "R2", "R8");
        stalled_attempt(0, 0, 0, "R9");
        // R10: fill the pool, then one extra release is dropped
        release_tag(2);
        release_tag(4);
        release_tag(1);
        release_tag(6);
        release_tag(5);
        rename(3, 3, 3, 5, 5, 2, 5, "R2", "R8");
        rename(0, 1, 0, 7, 0, 4, 7, "R2", "R8");
        rename(1, 2, 1, 0, 3, 1, 0, "R2", "R8");
        rename(2, 0, 2, 3, 4, 6, 3, "R2", "R10");
        stalled_attempt(3, 3, 3, "R10");
        drive(1'b0, 0, 0, 0, 1'b0, 0);
        @(negedge clk);
        chk(sb.size() == 0, "R3", "pending expected results", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule